// File: doc/BRIEF.md
# Accumulator Strand Execution Element

This block is one in-order execution element for a machine that splits a program into chains of dependent instructions. A steering stage pushes decoded instructions into the element's 8-entry issue queue. The element executes them one at a time, in push order. Values inside a chain pass through a single local accumulator. Values between chains pass through general-purpose registers (GPRs). Which accumulator name a chain uses is settled before an instruction reaches the element, so the element holds only the one accumulator register.

The element keeps its own copy of the 64-entry GPR file. When the element writes a GPR, the value goes onto a broadcast-out port and reaches the local copy two cycles later, the same latency the other elements see. Broadcasts from other elements arrive on a broadcast-in port, where the network has already delayed them, and are written into the local copy at once. An instruction that names a GPR with a local write still in flight waits until that write has landed. Loads and stores use a simple request/response memory port with one access outstanding. The address is taken straight from the accumulator or the GPR, with no displacement added.

Top module: `strand_pe`

## Requirements
- R1: After reset the accumulator and every local GPR read as 0. The queue is empty, `push_ready_o` is 1, and `bc_out_valid_o` and `mem_req_o` are 0.
- R2: An instruction accepted at clock edge P executes at edge P+1 if it is not held back. `acc_o` shows its result after that edge. `acc_o` does not change on any edge where no instruction executes or completes.
- R3: ALU codes on `push_op_i` are 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, and 7 scaled add (a*8+b). Shifts use the low 5 bits of b.
- R4: Accumulator-destination forms on `push_form_i` are 0: acc = acc op R[gpr], 1: acc = acc op imm, and 2: acc = R[gpr] op imm.
- R5: GPR-destination forms are 3: R[gpr] = acc and 4: R[gpr] = acc op imm. After the executing edge, `bc_out_*` carries the index, the value and the instruction's `push_seq_i` for exactly one cycle. The local copy holds the value two edges after execution.
- R6: An instruction that names a GPR whose local write has not yet landed is held until the edge after the landing edge.
- R7: A valid `bc_in_*` write is stored in the local GPR copy at the next edge.
- R8: If a local write lands and an incoming broadcast targets the same GPR on the same edge, the value with the younger sequence tag is kept. Tag age is compared modulo 2^8: a is older than b when bit 7 of (a-b) is 1.
- R9: Memory forms are 5: acc = mem[acc], 6: acc = mem[R[gpr]], 7: mem[acc] = R[gpr], and 8: mem[R[gpr]] = acc. `mem_addr_o` is the operand unchanged and `mem_we_o` is 1 for stores. `mem_req_o` is high for one cycle per access. The instruction completes on the edge where `mem_rsp_i` is 1, and a load writes `mem_rdata_i` to the accumulator on that edge.
- R10: `push_ready_o` is 0 while the queue is full and from the edge after a memory request until the response edge. A push offered while not ready is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Instruction offered |
| push_ready_o | output | 1 | Element accepts an instruction this cycle |
| push_form_i | input | 4 | Instruction form code |
| push_op_i | input | 3 | ALU operation code |
| push_gpr_i | input | 6 | GPR index named by the instruction |
| push_imm_i | input | 32 | Immediate operand |
| push_seq_i | input | 8 | Program-order sequence tag |
| bc_out_valid_o | output | 1 | Local GPR write broadcast valid |
| bc_out_idx_o | output | 6 | Broadcast GPR index |
| bc_out_data_o | output | 32 | Broadcast value |
| bc_out_seq_o | output | 8 | Broadcast sequence tag |
| bc_in_valid_i | input | 1 | Incoming GPR write valid |
| bc_in_idx_i | input | 6 | Incoming GPR index |
| bc_in_data_i | input | 32 | Incoming value |
| bc_in_seq_i | input | 8 | Incoming sequence tag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Store data |
| mem_rsp_i | input | 1 | Access complete |
| mem_rdata_i | input | 32 | Load data |
| acc_o | output | 32 | Local accumulator |

## Verification
The bench drives inputs and samples outputs on falling edges, so every deadline is counted in rising edges after the push edge P.

- ALU results show on `acc_o` after edge P+1.
- A GPR broadcast is visible for exactly the cycle after P+1.
- A read held back by an in-flight write executes at P+4 when it directly follows the writer and one other instruction. The bench checks at P+3 that the accumulator is still unchanged, then checks the new value at P+4.
- With the bench's one-cycle memory, a load's data reaches the accumulator at P+2. A same-edge collision is set up by driving the incoming broadcast so that it arrives at the landing edge P+3 of a write pushed at P.

// File: rtl/strand_pe_pkg.sv
package strand_pe_pkg;
  parameter int XLEN  = 32;
  parameter int NGPR  = 64;
  parameter int SEQ_W = 8;
  localparam int GPR_W = $clog2(NGPR);

  typedef enum logic [3:0] {
    F_ACC_R   = 4'd0,
    F_ACC_I   = 4'd1,
    F_R_I     = 4'd2,
    F_MOV_R   = 4'd3,
    F_R_ACC_I = 4'd4,
    F_LD_A    = 4'd5,
    F_LD_R    = 4'd6,
    F_ST_A    = 4'd7,
    F_ST_R    = 4'd8
  } form_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRL, OP_ADD8
  } aluop_e;

  typedef struct packed {
    form_e             form;
    aluop_e            op;
    logic [GPR_W-1:0]  gpr;
    logic [XLEN-1:0]   imm;
    logic [SEQ_W-1:0]  seq;
  } instr_t;

  typedef struct packed {
    logic              vld;
    logic [GPR_W-1:0]  idx;
    logic [XLEN-1:0]   data;
    logic [SEQ_W-1:0]  seq;
  } gwr_t;

  // a older than b, modulo tag wrap
  function automatic logic seq_older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/pe_fifo.sv
module pe_fifo
  import strand_pe_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  instr_t din_i,
  input  logic   pop_i,
  output instr_t dout_o,
  output logic   empty_o,
  output logic   full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  instr_t             mem_q [DEPTH];
  logic [PTR_W-1:0]   wr_q, rd_q;
  logic [CNT_W-1:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import strand_pe_pkg::*;
(
  input  aluop_e          op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0] sh;
  assign sh = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_SLL:  y_o = a_i << sh;
      OP_SRL:  y_o = a_i >> sh;
      OP_ADD8: y_o = (a_i << 3) + b_i;
    endcase
  end
endmodule

// File: rtl/pe_gpr_copy.sv
module pe_gpr_copy
  import strand_pe_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GPR_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rd_pend_o,
  input  gwr_t             loc_wr_i,
  input  gwr_t             bc_in_i,
  output gwr_t             bc_out_o
);
  logic [XLEN-1:0] rf_q [NGPR];
  logic [NGPR-1:0] pend_q;
  gwr_t            dl_q [LAT];
  gwr_t            land;

  // stage 0 is what leaves the element; last stage lands locally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dl_q[0] <= '0;
    else         dl_q[0] <= loc_wr_i;
  end

  for (genvar k = 1; k < LAT; k++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dl_q[k] <= '0;
      else         dl_q[k] <= dl_q[k-1];
    end
  end

  assign land      = dl_q[LAT-1];
  assign bc_out_o  = dl_q[0];
  assign rd_data_o = rf_q[rd_idx_i];
  assign rd_pend_o = pend_q[rd_idx_i];

  logic bc_loses;
  assign bc_loses = land.vld && (land.idx == bc_in_i.idx) && seq_older(bc_in_i.seq, land.seq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NGPR; i++) rf_q[i] <= '0;
    end else begin
      if (land.vld) rf_q[land.idx] <= land.data;
      if (bc_in_i.vld && !bc_loses) rf_q[bc_in_i.idx] <= bc_in_i.data;
    end
  end

  logic [NGPR-1:0] set_v, clr_v;
  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (loc_wr_i.vld) set_v[loc_wr_i.idx] = 1'b1;
    if (land.vld)     clr_v[land.idx]     = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/strand_pe.sv
module strand_pe
  import strand_pe_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int BC_LAT     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  output logic             push_ready_o,
  input  logic [3:0]       push_form_i,
  input  logic [2:0]       push_op_i,
  input  logic [GPR_W-1:0] push_gpr_i,
  input  logic [XLEN-1:0]  push_imm_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  output logic             bc_out_valid_o,
  output logic [GPR_W-1:0] bc_out_idx_o,
  output logic [XLEN-1:0]  bc_out_data_o,
  output logic [SEQ_W-1:0] bc_out_seq_o,
  input  logic             bc_in_valid_i,
  input  logic [GPR_W-1:0] bc_in_idx_i,
  input  logic [XLEN-1:0]  bc_in_data_i,
  input  logic [SEQ_W-1:0] bc_in_seq_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic             mem_rsp_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic [XLEN-1:0]  acc_o
);
  instr_t push_ins, head;
  logic   q_empty, q_full, push_fire, pop;
  logic   waiting_q, exec_fire, can_go, hazard;
  logic   uses_gpr, writes_gpr, to_acc, is_mem, is_load, acc_addr;
  logic [XLEN-1:0] acc_q, rf_rd, alu_a, alu_b, alu_y;
  logic   rd_pend;
  gwr_t   loc_wr, bc_in, bc_out;

  assign push_ins = '{form: form_e'(push_form_i), op: aluop_e'(push_op_i),
                      gpr: push_gpr_i, imm: push_imm_i, seq: push_seq_i};
  assign push_ready_o = !q_full && !waiting_q;
  assign push_fire    = push_valid_i && push_ready_o;

  pe_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push_fire), .din_i(push_ins),
    .pop_i(pop), .dout_o(head), .empty_o(q_empty), .full_o(q_full)
  );

  always_comb begin
    uses_gpr = 1'b1; writes_gpr = 1'b0; to_acc = 1'b0;
    is_mem = 1'b0; is_load = 1'b0; acc_addr = 1'b0;
    unique case (head.form)
      F_ACC_R:   to_acc = 1'b1;
      F_ACC_I:   begin to_acc = 1'b1; uses_gpr = 1'b0; end
      F_R_I:     to_acc = 1'b1;
      F_MOV_R,
      F_R_ACC_I: writes_gpr = 1'b1;
      F_LD_A:    begin is_mem = 1'b1; is_load = 1'b1; acc_addr = 1'b1; uses_gpr = 1'b0; end
      F_LD_R:    begin is_mem = 1'b1; is_load = 1'b1; end
      F_ST_A:    begin is_mem = 1'b1; acc_addr = 1'b1; end
      F_ST_R:    is_mem = 1'b1;
      default:   uses_gpr = 1'b0;
    endcase
  end

  assign hazard    = uses_gpr && rd_pend;
  assign can_go    = !q_empty && !hazard && !waiting_q;
  assign exec_fire = can_go && !is_mem;
  assign mem_req_o = can_go && is_mem;
  assign pop       = exec_fire || (waiting_q && mem_rsp_i);

  assign alu_a = (head.form == F_R_I)   ? rf_rd : acc_q;
  assign alu_b = (head.form == F_ACC_R) ? rf_rd : head.imm;

  pe_alu u_alu (.op_i(head.op), .a_i(alu_a), .b_i(alu_b), .y_o(alu_y));

  assign mem_we_o    = mem_req_o && !is_load;
  assign mem_addr_o  = acc_addr ? acc_q : rf_rd;
  assign mem_wdata_o = (head.form == F_ST_A) ? rf_rd : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      acc_q     <= '0;
    end else begin
      if (mem_req_o)                   waiting_q <= 1'b1;
      else if (waiting_q && mem_rsp_i) waiting_q <= 1'b0;
      if (exec_fire && to_acc)                       acc_q <= alu_y;
      else if (waiting_q && mem_rsp_i && is_load)    acc_q <= mem_rdata_i;
    end
  end

  assign loc_wr = '{vld: exec_fire && writes_gpr, idx: head.gpr,
                    data: (head.form == F_MOV_R) ? acc_q : alu_y, seq: head.seq};
  assign bc_in  = '{vld: bc_in_valid_i, idx: bc_in_idx_i, data: bc_in_data_i, seq: bc_in_seq_i};

  pe_gpr_copy #(.LAT(BC_LAT)) u_gpr (
    .clk_i, .rst_ni, .rd_idx_i(head.gpr), .rd_data_o(rf_rd), .rd_pend_o(rd_pend),
    .loc_wr_i(loc_wr), .bc_in_i(bc_in), .bc_out_o(bc_out)
  );

  assign bc_out_valid_o = bc_out.vld;
  assign bc_out_idx_o   = bc_out.idx;
  assign bc_out_data_o  = bc_out.data;
  assign bc_out_seq_o   = bc_out.seq;
  assign acc_o          = acc_q;
endmodule

// File: rtl/strand_pe_chk.sv
module strand_pe_chk
  import strand_pe_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            push_ready_o,
  input logic            mem_req_o,
  input logic            mem_rsp_i,
  input logic            bc_out_valid_o,
  input logic [XLEN-1:0] acc_o,
  input logic            fire_i
);
  assert_mem_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_busy_not_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !push_ready_o);

  assert_bc_after_exec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_out_valid_o |-> $past(fire_i));

  assert_acc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(fire_i) && !$past(mem_rsp_i)) |-> $stable(acc_o));
endmodule

bind strand_pe strand_pe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_ready_o(push_ready_o),
  .mem_req_o(mem_req_o), .mem_rsp_i(mem_rsp_i), .bc_out_valid_o(bc_out_valid_o),
  .acc_o(acc_o), .fire_i(exec_fire)
);

// File: tb/tb_strand_pe.sv
module tb_strand_pe;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        push_valid_i = 1'b0, push_ready_o;
  logic [3:0]  push_form_i = '0;
  logic [2:0]  push_op_i = '0;
  logic [5:0]  push_gpr_i = '0;
  logic [31:0] push_imm_i = '0;
  logic [7:0]  push_seq_i = '0;
  logic        bc_out_valid_o;
  logic [5:0]  bc_out_idx_o;
  logic [31:0] bc_out_data_o;
  logic [7:0]  bc_out_seq_o;
  logic        bc_in_valid_i = 1'b0;
  logic [5:0]  bc_in_idx_i = '0;
  logic [31:0] bc_in_data_i = '0;
  logic [7:0]  bc_in_seq_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rsp_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] acc_o;

  strand_pe dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;

  // one-cycle memory model; load data = addr ^ 5A5A0000
  logic        mem_flag = 1'b0;
  logic [31:0] cap_addr = '0, cap_wdata = '0;
  logic        cap_we = 1'b0;
  always @(negedge clk_i) begin
    mem_rsp_i = 1'b0;
    if (mem_flag) begin
      mem_rsp_i   = 1'b1;
      mem_rdata_i = cap_addr ^ 32'h5A5A_0000;
      mem_flag    = 1'b0;
    end
    if (mem_req_o) begin
      mem_flag  = 1'b1;
      cap_addr  = mem_addr_o;
      cap_we    = mem_we_o;
      cap_wdata = mem_wdata_o;
    end
  end

  typedef struct packed {logic [2:0] op; logic [31:0] a; logic [31:0] b;} vec_t;
  localparam vec_t VECS [8] = '{
    '{3'd0, 32'h7FFF_FFFF, 32'h0000_0001},
    '{3'd1, 32'h0000_0005, 32'h0000_0007},
    '{3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF},
    '{3'd3, 32'h0000_1200, 32'h0000_0034},
    '{3'd4, 32'hAAAA_5555, 32'hFFFF_0000},
    '{3'd5, 32'h0000_0001, 32'h0000_0021},
    '{3'd6, 32'h8000_0000, 32'h0000_001F},
    '{3'd7, 32'h0000_0010, 32'h0000_0003}
  };

  function automatic logic [31:0] alu_ref(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return a >> b[4:0];
      default: return a * 8 + b;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accept edge
  task automatic push(logic [3:0] form, logic [2:0] op, logic [5:0] gpr,
                      logic [31:0] imm, logic [7:0] seq);
    while (!push_ready_o) @(negedge clk_i);
    push_valid_i = 1'b1; push_form_i = form; push_op_i = op;
    push_gpr_i = gpr; push_imm_i = imm; push_seq_i = seq;
    @(negedge clk_i);
    push_valid_i = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_acc(logic [31:0] v);
    push(4'd2, 3'd0, 6'd63, v, 8'd0);
  endtask

  task automatic collide(string req, logic [5:0] g, logic [31:0] lv, logic [7:0] ls,
                         logic [31:0] bv, logic [7:0] bs, logic [31:0] exp);
    set_acc(lv);
    push(4'd3, 3'd0, g, 32'd0, ls);
    run(2);
    bc_in_valid_i = 1'b1; bc_in_idx_i = g; bc_in_data_i = bv; bc_in_seq_i = bs;
    run(1);
    bc_in_valid_i = 1'b0;
    run(2);
    push(4'd2, 3'd0, g, 32'd0, 8'd0);
    run(3);
    check(req, acc_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    rst_ni = 1'b1;
    run(1);
    // R1 reset state
    check("R1 acc", acc_o, 0);
    check("R1 ready", 32'(push_ready_o), 1);
    check("R1 bc_out", 32'(bc_out_valid_o), 0);
    check("R1 mem_req", 32'(mem_req_o), 0);

    // R2 executes one edge after the push edge
    push(4'd1, 3'd0, 6'd0, 32'd5, 8'd0);
    check("R2 before exec", acc_o, 0);
    run(1);
    check("R2 after exec", acc_o, 5);

    // R1 local GPR copy reads 0
    set_acc(32'h99);
    push(4'd2, 3'd0, 6'd7, 32'd0, 8'd0);
    run(3);
    check("R1 gpr zero", acc_o, 0);

    // R3 vector table: acc = a, then acc = acc op b
    for (int i = 0; i < 8; i++) begin
      set_acc(VECS[i].a);
      push(4'd1, VECS[i].op, 6'd0, VECS[i].b, 8'd0);
      run(2);
      check($sformatf("R3 op%0d", i), acc_o, alu_ref(VECS[i].op, VECS[i].a, VECS[i].b));
    end

    // R5 broadcast out, one cycle, after exec edge
    set_acc(32'h1234);
    push(4'd3, 3'd0, 6'd10, 32'd0, 8'h11);
    run(1);
    check("R5 bc valid", 32'(bc_out_valid_o), 1);
    check("R5 bc idx", 32'(bc_out_idx_o), 10);
    check("R5 bc data", bc_out_data_o, 32'h1234);
    check("R5 bc seq", 32'(bc_out_seq_o), 32'h11);
    run(1);
    check("R5 bc one cycle", 32'(bc_out_valid_o), 0);

    // R4 acc = acc op R10 (R10 = 1234)
    set_acc(32'h5000);
    push(4'd0, 3'd1, 6'd10, 32'd0, 8'd0);
    run(2);
    check("R4 acc op gpr", acc_o, 32'h5000 - 32'h1234);
    // R4 acc = R10 op imm
    push(4'd2, 3'd4, 6'd10, 32'hFFFF, 8'd0);
    run(2);
    check("R4 gpr op imm", acc_o, 32'h1234 ^ 32'hFFFF);

    // R5 R11 = acc - 1
    set_acc(32'h100);
    push(4'd4, 3'd1, 6'd11, 32'd1, 8'd3);
    run(4);
    push(4'd2, 3'd0, 6'd11, 32'd0, 8'd0);
    run(2);
    check("R5 gpr op form", acc_o, 32'hFF);

    // R6 read held until local write lands
    set_acc(32'h55);
    push(4'd3, 3'd0, 6'd12, 32'd0, 8'd4);
    push(4'd1, 3'd0, 6'd0, 32'd1, 8'd5);
    push(4'd2, 3'd0, 6'd12, 32'd0, 8'd6);
    run(1);
    check("R6 still held", acc_o, 32'h56);
    run(1);
    check("R6 after landing", acc_o, 32'h55);

    // R7 incoming broadcast
    bc_in_valid_i = 1'b1; bc_in_idx_i = 6'd20; bc_in_data_i = 32'hCAFE; bc_in_seq_i = 8'd9;
    run(1);
    bc_in_valid_i = 1'b0;
    push(4'd2, 3'd0, 6'd20, 32'd0, 8'd0);
    run(2);
    check("R7 bc_in stored", acc_o, 32'hCAFE);

    // R8 same-edge collisions
    collide("R8 incoming younger", 6'd30, 32'hA1, 8'd10, 32'hB1, 8'd11, 32'hB1);
    collide("R8 local younger",    6'd31, 32'hA2, 8'd21, 32'hB2, 8'd20, 32'hA2);
    collide("R8 tag wrap",         6'd32, 32'hA3, 8'hFE, 32'hB3, 8'h01, 32'hB3);

    // R9 load through acc; R10 push during wait ignored
    set_acc(32'h40);
    push(4'd5, 3'd0, 6'd0, 32'd0, 8'd0);
    run(1);
    check("R9 load pending", acc_o, 32'h40);
    check("R10 not ready", 32'(push_ready_o), 0);
    push_valid_i = 1'b1; push_form_i = 4'd1; push_op_i = 3'd0; push_imm_i = 32'h1000;
    run(1);
    push_valid_i = 1'b0;
    check("R9 load data", acc_o, 32'h40 ^ 32'h5A5A_0000);
    run(3);
    check("R10 push ignored", acc_o, 32'h40 ^ 32'h5A5A_0000);
    check("R9 load addr", cap_addr, 32'h40);
    check("R9 load we", 32'(cap_we), 0);

    // R9 load through GPR
    push(4'd6, 3'd0, 6'd20, 32'd0, 8'd0);
    run(3);
    check("R9 load gpr addr", cap_addr, 32'hCAFE);
    check("R9 load gpr data", acc_o, 32'hCAFE ^ 32'h5A5A_0000);

    // R9 stores
    set_acc(32'h80);
    push(4'd7, 3'd0, 6'd20, 32'd0, 8'd0);
    run(4);
    check("R9 st_a addr", cap_addr, 32'h80);
    check("R9 st_a data", cap_wdata, 32'hCAFE);
    check("R9 st_a we", 32'(cap_we), 1);
    set_acc(32'h77);
    push(4'd8, 3'd0, 6'd20, 32'd0, 8'd0);
    run(4);
    check("R9 st_r addr", cap_addr, 32'hCAFE);
    check("R9 st_r data", cap_wdata, 32'h77);
    check("R9 store keeps acc", acc_o, 32'h77);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule